// File: doc/BRIEF.md
# DMA Page Address Generator

This block extends the 16-bit transfer offsets of a pair of cascaded four-channel DMA controllers into 24-bit memory addresses. Software programs a file of sixteen 8-bit page registers through a small I/O port. The block watches the controllers' active-low per-channel acknowledge lines to learn which channel owns the bus. On each controller memory request it issues a registered memory read or write at the address formed from that channel's page byte and the transfer offset.

Channels 0 to 3 move bytes. Channels 4 to 7 move 16-bit words. For a word channel the page byte loses its low bit and the offset is doubled. The upper byte of each word read is kept in a holding register, and the next word write sends it back out, so an 8-bit data path carries 16-bit transfers. Channel 4 is the link between the two controllers and has no page register. The block also forwards the controllers' end-of-process as a terminal-count signal, tagged with the active channel.

Top module: `dma_page_gen`

## Requirements
- R1: Sixteen 8-bit page registers are written when `io_we` is high at the clock edge (index `io_addr`, data `io_wdata`). `io_rdata` shows the register selected by `io_addr` one clock later. All of them reset to 0x00.
- R2: A high-to-low change on `dack_n[i]` makes channel i active (`busy`=1, `act_chan`=i) one clock after it is sampled, even if another channel was active. If several lines fall together, the lowest index wins. A low-to-high change releases the active channel only when it belongs to that channel; a rising edge on any other line has no effect.
- R3: The channel-to-page-register map is 0→7, 1→3, 2→1, 3→2, 5→0xB, 6→9, 7→0xA. Channel 4 has no register and uses page 0xFF.
- R4: On a byte channel (0–3) the address is {page[7:0], offset[15:0]}, and `mem_word`=0.
- R5: On a word channel (4–7) the address is {page[7:1], offset[15:0], 1'b0}, and `mem_word`=1, so address bit 0 is always 0.
- R6: When `mem_rvalid` returns data, `ctl_rdata` gets `mem_rdata[7:0]` and `ctl_rvalid` pulses one clock later. If the pending read came from a word channel, `mem_rdata[15:8]` is also stored in the holding register.
- R7: A word-channel write drives `mem_wdata` = {holding byte, `ctl_wdata`}. A byte-channel write drives {0x00, `ctl_wdata`}.
- R8: With no channel active, a read request creates no memory read and returns 0xFF on `ctl_rdata` with a `ctl_rvalid` pulse one clock later. A write request creates no memory write. The holding register resets to 0xFF.
- R9: `tc_out` equals end-of-process AND active state, and `tc_chan` names the active channel. Both change in the same clock as `busy`, so terminal count rises or falls when a channel enters or leaves while `eop` is held high.
- R10: After reset the block has no active channel, `tc_out`=0, no memory strobes, and `ctl_rdata`=0xFF.
- R11: `mem_re`/`mem_we`, `mem_addr`, `mem_word` and `mem_wdata` are registered one clock after the request. A read request takes priority over a write request in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 4 | Page register index |
| io_we | input | 1 | Page register write strobe |
| io_wdata | input | 8 | Page register write data |
| io_rdata | output | 8 | Registered page register read data |
| dack_n | input | 8 | Per-channel active-low acknowledge |
| eop | input | 1 | End-of-process from the controllers |
| xfer_off | input | 16 | Controller transfer offset |
| rd_req | input | 1 | Controller memory read request |
| wr_req | input | 1 | Controller memory write request |
| ctl_wdata | input | 8 | Controller write data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 16 | Memory read data |
| mem_addr | output | 24 | Memory address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_word | output | 1 | Access is 16-bit |
| mem_wdata | output | 16 | Memory write data |
| ctl_rdata | output | 8 | Data returned to the controller |
| ctl_rvalid | output | 1 | Controller read data valid |
| busy | output | 1 | A channel is active |
| act_chan | output | 3 | Active channel number |
| tc_out | output | 1 | Terminal count to the bus |
| tc_chan | output | 3 | Channel tagged on terminal count |

## Verification
A wrong active-channel state shows at the ports one clock after the acknowledge edge, as wrong `busy`/`act_chan`. It also shows as a wrong page field in `mem_addr` on the next request. A corrupted holding byte stays hidden until the next word write, where it appears in the upper half of `mem_wdata`. For that reason every word channel is read and then written back. A wrong map entry shows only when its own channel is active, so each of the eight channels is driven with a distinct page value, and odd pages are used to expose a missing bit-0 clear.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;

  typedef struct packed {
    logic       hit;
    logic [3:0] idx;
  } page_sel_t;

  // Fixed channel-to-page-register map; the cascade channel has no entry.
  function automatic page_sel_t chan_to_page(input logic [2:0] ch);
    page_sel_t s;
    s.hit = 1'b1;
    case (ch)
      3'd0:    s.idx = 4'h7;
      3'd1:    s.idx = 4'h3;
      3'd2:    s.idx = 4'h1;
      3'd3:    s.idx = 4'h2;
      3'd5:    s.idx = 4'hB;
      3'd6:    s.idx = 4'h9;
      3'd7:    s.idx = 4'hA;
      default: begin s.hit = 1'b0; s.idx = 4'h0; end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dma_page_file.sv
module dma_page_file #(
  parameter int DATA_W = 8,
  parameter int NREGS  = 16,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [DATA_W-1:0] lk_data
);

  logic [DATA_W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) regs[addr] <= wdata;
      rd_data <= regs[addr];
    end
  end

  // Lookup port for the address path: old value during a same-cycle write.
  assign lk_data = regs[lk_idx];

endmodule

// File: rtl/dma_chan_track.sv
module dma_chan_track #(
  parameter int NCHAN = 8,
  localparam int CH_W = $clog2(NCHAN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCHAN-1:0] ack_n,
  input  logic             eop,
  output logic             busy,
  output logic [CH_W-1:0]  chan,
  output logic             tc,
  output logic [CH_W-1:0]  tc_chan
);

  logic [NCHAN-1:0] ack_q;
  logic [NCHAN-1:0] fall, rise;
  logic             nxt_busy;
  logic [CH_W-1:0]  nxt_chan;

  assign fall = ack_q & ~ack_n;
  assign rise = ~ack_q & ack_n;

  always_comb begin
    nxt_busy = busy;
    nxt_chan = chan;
    if (busy && rise[chan]) nxt_busy = 1'b0;
    for (int i = NCHAN - 1; i >= 0; i--) begin
      if (fall[i]) begin
        nxt_busy = 1'b1;
        nxt_chan = CH_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= '1;
      busy    <= 1'b0;
      chan    <= '0;
      tc      <= 1'b0;
      tc_chan <= '0;
    end else begin
      ack_q   <= ack_n;
      busy    <= nxt_busy;
      chan    <= nxt_chan;
      tc      <= eop & nxt_busy;
      tc_chan <= nxt_chan;
    end
  end

endmodule

// File: rtl/dma_addr_path.sv
module dma_addr_path #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 16,
  parameter int NCHAN  = 8,
  localparam int CH_W   = $clog2(NCHAN),
  localparam int ADDR_W = DATA_W + OFF_W,
  localparam int HALF   = NCHAN / 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busy,
  input  logic [CH_W-1:0]     chan,
  input  logic [DATA_W-1:0]   page,
  input  logic [OFF_W-1:0]    offset,
  input  logic                rd_req,
  input  logic                wr_req,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                rvalid,
  input  logic [2*DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_re,
  output logic                mem_we,
  output logic                mem_word,
  output logic [2*DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0]   ctl_rdata,
  output logic                ctl_rvalid
);

  logic              is_word;
  logic [ADDR_W-1:0] addr_c;
  logic [DATA_W-1:0] hold;
  logic              pend_word;

  assign is_word = (32'(chan) >= HALF);
  assign addr_c  = is_word ? {page[DATA_W-1:1], offset, 1'b0} : {page, offset};

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_re     <= 1'b0;
      mem_we     <= 1'b0;
      mem_word   <= 1'b0;
      mem_wdata  <= '0;
      ctl_rdata  <= '1;
      ctl_rvalid <= 1'b0;
      hold       <= '1;
      pend_word  <= 1'b0;
    end else begin
      mem_re     <= 1'b0;
      mem_we     <= 1'b0;
      ctl_rvalid <= 1'b0;
      if (busy && rd_req) begin
        mem_re    <= 1'b1;
        mem_addr  <= addr_c;
        mem_word  <= is_word;
        pend_word <= is_word;
      end else if (busy && wr_req) begin
        mem_we    <= 1'b1;
        mem_addr  <= addr_c;
        mem_word  <= is_word;
        mem_wdata <= is_word ? {hold, wdata} : {{DATA_W{1'b0}}, wdata};
      end
      if (rvalid) begin
        ctl_rvalid <= 1'b1;
        ctl_rdata  <= rdata[DATA_W-1:0];
        if (pend_word) hold <= rdata[2*DATA_W-1:DATA_W];
      end else if (!busy && rd_req) begin
        ctl_rvalid <= 1'b1;
        ctl_rdata  <= '1;
      end
    end
  end

endmodule

// File: rtl/dma_page_gen.sv
module dma_page_gen #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 16,
  parameter int NCHAN  = 8,
  parameter int NREGS  = 16,
  localparam int IDX_W  = $clog2(NREGS),
  localparam int CH_W   = $clog2(NCHAN),
  localparam int ADDR_W = DATA_W + OFF_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IDX_W-1:0]    io_addr,
  input  logic                io_we,
  input  logic [DATA_W-1:0]   io_wdata,
  output logic [DATA_W-1:0]   io_rdata,
  input  logic [NCHAN-1:0]    dack_n,
  input  logic                eop,
  input  logic [OFF_W-1:0]    xfer_off,
  input  logic                rd_req,
  input  logic                wr_req,
  input  logic [DATA_W-1:0]   ctl_wdata,
  input  logic                mem_rvalid,
  input  logic [2*DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_re,
  output logic                mem_we,
  output logic                mem_word,
  output logic [2*DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0]   ctl_rdata,
  output logic                ctl_rvalid,
  output logic                busy,
  output logic [CH_W-1:0]     act_chan,
  output logic                tc_out,
  output logic [CH_W-1:0]     tc_chan
);
  import dma_page_pkg::*;

  page_sel_t         sel;
  logic [IDX_W-1:0]  lk_idx;
  logic [DATA_W-1:0] lk_data;
  logic [DATA_W-1:0] page;

  assign sel    = chan_to_page(3'(act_chan));
  assign lk_idx = IDX_W'(sel.idx);
  assign page   = sel.hit ? lk_data : {DATA_W{1'b1}};

  dma_page_file #(.DATA_W(DATA_W), .NREGS(NREGS)) u_file (
    .clk(clk), .rst(rst), .wr_en(io_we), .addr(io_addr), .wdata(io_wdata),
    .rd_data(io_rdata), .lk_idx(lk_idx), .lk_data(lk_data)
  );

  dma_chan_track #(.NCHAN(NCHAN)) u_track (
    .clk(clk), .rst(rst), .ack_n(dack_n), .eop(eop),
    .busy(busy), .chan(act_chan), .tc(tc_out), .tc_chan(tc_chan)
  );

  dma_addr_path #(.DATA_W(DATA_W), .OFF_W(OFF_W), .NCHAN(NCHAN)) u_path (
    .clk(clk), .rst(rst), .busy(busy), .chan(act_chan), .page(page),
    .offset(xfer_off), .rd_req(rd_req), .wr_req(wr_req), .wdata(ctl_wdata),
    .rvalid(mem_rvalid), .rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_word(mem_word),
    .mem_wdata(mem_wdata), .ctl_rdata(ctl_rdata), .ctl_rvalid(ctl_rvalid)
  );

endmodule

// File: rtl/dma_page_gen_chk.sv
module dma_page_gen_chk #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 16,
  parameter int NCHAN  = 8,
  localparam int CH_W   = $clog2(NCHAN),
  localparam int ADDR_W = DATA_W + OFF_W
) (
  input logic              clk,
  input logic              rst,
  input logic [NCHAN-1:0]  dack_n,
  input logic              rd_req,
  input logic              wr_req,
  input logic              mem_rvalid,
  input logic              busy,
  input logic [CH_W-1:0]   act_chan,
  input logic              tc_out,
  input logic [CH_W-1:0]   tc_chan,
  input logic              mem_re,
  input logic              mem_we,
  input logic              mem_word,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ctl_rvalid,
  input logic [DATA_W-1:0] ctl_rdata
);

  p_tc_tagged_r9: assert property (@(posedge clk) disable iff (rst)
    tc_out |-> (busy && tc_chan == act_chan));

  p_idle_no_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !busy) |=> !mem_re);

  p_idle_ff_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !busy && !mem_rvalid) |=> (ctl_rvalid && ctl_rdata == '1));

  p_idle_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !rd_req && !busy) |=> !mem_we);

  p_word_even_r5: assert property (@(posedge clk) disable iff (rst)
    ((mem_re || mem_we) && mem_word) |-> !mem_addr[0]);

  p_req_issues_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_req && busy) |=> mem_re);

  p_hold_state_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && dack_n == $past(dack_n)) |=> (busy && $stable(act_chan)));

endmodule

bind dma_page_gen dma_page_gen_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W), .NCHAN(NCHAN)) u_chk (
  .clk(clk), .rst(rst), .dack_n(dack_n), .rd_req(rd_req), .wr_req(wr_req),
  .mem_rvalid(mem_rvalid), .busy(busy), .act_chan(act_chan), .tc_out(tc_out),
  .tc_chan(tc_chan), .mem_re(mem_re), .mem_we(mem_we), .mem_word(mem_word),
  .mem_addr(mem_addr), .ctl_rvalid(ctl_rvalid), .ctl_rdata(ctl_rdata)
);

// File: tb/tb_dma_page_gen.sv
module tb_dma_page_gen;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  io_addr;
  logic        io_we;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic [7:0]  dack_n;
  logic        eop;
  logic [15:0] xfer_off;
  logic        rd_req, wr_req;
  logic [7:0]  ctl_wdata;
  logic        mem_rvalid;
  logic [15:0] mem_rdata;
  logic [23:0] mem_addr;
  logic        mem_re, mem_we, mem_word;
  logic [15:0] mem_wdata;
  logic [7:0]  ctl_rdata;
  logic        ctl_rvalid;
  logic        busy;
  logic [2:0]  act_chan;
  logic        tc_out;
  logic [2:0]  tc_chan;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dma_page_gen dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_we(io_we), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .dack_n(dack_n), .eop(eop), .xfer_off(xfer_off),
    .rd_req(rd_req), .wr_req(wr_req), .ctl_wdata(ctl_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_word(mem_word),
    .mem_wdata(mem_wdata), .ctl_rdata(ctl_rdata), .ctl_rvalid(ctl_rvalid),
    .busy(busy), .act_chan(act_chan), .tc_out(tc_out), .tc_chan(tc_chan)
  );

  // {channel, offset, expected address}; page register i holds 0x30+i.
  localparam int NV = 8;
  localparam logic [42:0] VEC [NV] = '{
    {3'd0, 16'h1234, 24'h371234},
    {3'd1, 16'hABCD, 24'h33ABCD},
    {3'd2, 16'h0000, 24'h310000},
    {3'd3, 16'hFFFF, 24'h32FFFF},
    {3'd4, 16'h0100, 24'hFE0200},
    {3'd5, 16'h1234, 24'h3A2468},
    {3'd6, 16'h8001, 24'h390002},
    {3'd7, 16'h7FFF, 24'h3AFFFE}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; io_addr = 4'h5; io_we = 1'b0; io_wdata = '0; dack_n = '1;
    eop = 1'b0; xfer_off = '0; rd_req = 1'b0; wr_req = 1'b0; ctl_wdata = '0;
    mem_rvalid = 1'b0; mem_rdata = '0;
    tick(); tick(); tick();
    // R10 reset state
    chk("R10 busy", 32'(busy), 0);
    chk("R10 tc_out", 32'(tc_out), 0);
    chk("R10 mem strobes", 32'({mem_re, mem_we}), 0);
    chk("R10 ctl_rdata", 32'(ctl_rdata), 32'hFF);
    chk("R1 reset page value", 32'(io_rdata), 0);
    rst = 1'b0;

    // R1 program and read back page registers
    for (int i = 0; i < 16; i++) begin
      io_we = 1'b1; io_addr = 4'(i); io_wdata = 8'(8'h30 + i);
      tick();
    end
    io_we = 1'b0;
    io_addr = 4'hB; tick(); chk("R1 readback B", 32'(io_rdata), 32'h3B);
    io_addr = 4'h0; tick(); chk("R1 readback 0", 32'(io_rdata), 32'h30);
    io_addr = 4'hF; tick(); chk("R1 readback F", 32'(io_rdata), 32'h3F);

    // R8 holding register resets to FF: word write before any word read
    dack_n = ~8'h20; tick();
    wr_req = 1'b1; ctl_wdata = 8'h5C; tick(); wr_req = 1'b0;
    chk("R8 hold reset mem_we", 32'(mem_we), 1);
    chk("R8 hold reset wdata", 32'(mem_wdata), 32'hFF5C);
    dack_n = '1; tick();
    chk("R2 release", 32'(busy), 0);

    // Table walk: R3 R4 R5 R6 R7 R11
    for (int k = 0; k < NV; k++) begin
      logic [2:0]  ch;
      logic [15:0] off;
      logic [23:0] ea;
      logic        wd;
      {ch, off, ea} = VEC[k];
      wd = (ch >= 3'd4);
      dack_n = ~(8'h01 << ch); tick();
      chk("R2 active", 32'(busy), 1);
      chk("R2 act_chan", 32'(act_chan), 32'(ch));
      xfer_off = off; rd_req = 1'b1; tick(); rd_req = 1'b0;
      chk("R11 mem_re", 32'(mem_re), 1);
      chk(wd ? "R3/R5 word addr" : "R3/R4 byte addr", 32'(mem_addr), 32'(ea));
      chk("R5 mem_word", 32'(mem_word), 32'(wd));
      mem_rvalid = 1'b1; mem_rdata = {8'(8'h90 + k), 8'(8'h60 + k)}; tick();
      mem_rvalid = 1'b0;
      chk("R6 ctl_rvalid", 32'(ctl_rvalid), 1);
      chk("R6 ctl_rdata", 32'(ctl_rdata), 32'(8'(8'h60 + k)));
      wr_req = 1'b1; ctl_wdata = 8'(8'hA0 + k); tick(); wr_req = 1'b0;
      chk("R7 mem_we", 32'(mem_we), 1);
      chk("R7 mem_wdata", 32'(mem_wdata),
          wd ? 32'({8'(8'h90 + k), 8'(8'hA0 + k)}) : 32'({8'h00, 8'(8'hA0 + k)}));
      dack_n = '1; tick();
    end

    // R8 idle accesses
    rd_req = 1'b1; tick(); rd_req = 1'b0;
    chk("R8 idle no mem_re", 32'(mem_re), 0);
    chk("R8 idle rvalid", 32'(ctl_rvalid), 1);
    chk("R8 idle data FF", 32'(ctl_rdata), 32'hFF);
    wr_req = 1'b1; tick(); wr_req = 1'b0;
    chk("R8 idle no mem_we", 32'(mem_we), 0);

    // R2 takeover and foreign release
    dack_n = ~8'h02; tick();
    dack_n = ~8'h0A; tick();
    chk("R2 takeover", 32'(act_chan), 3);
    dack_n = ~8'h08; tick();
    chk("R2 foreign rise busy", 32'(busy), 1);
    chk("R2 foreign rise chan", 32'(act_chan), 3);
    dack_n = '1; tick();
    chk("R2 own rise", 32'(busy), 0);
    dack_n = ~8'h44; tick();
    chk("R2 lowest wins", 32'(act_chan), 2);
    dack_n = '1; tick();

    // R9 terminal count
    eop = 1'b1; tick();
    chk("R9 idle tc", 32'(tc_out), 0);
    dack_n = ~8'h40; tick();
    chk("R9 enter tc", 32'(tc_out), 1);
    chk("R9 tc_chan", 32'(tc_chan), 6);
    eop = 1'b0; tick();
    chk("R9 eop low", 32'(tc_out), 0);
    eop = 1'b1; tick();
    chk("R9 eop high", 32'(tc_out), 1);
    dack_n = '1; tick();
    chk("R9 leave tc", 32'(tc_out), 0);
    chk("R9 leave busy", 32'(busy), 0);
    eop = 1'b0; tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule